// File: doc/BRIEF.md
# Configuration Write Guard with Initialisation Handshake

This block stands in front of a bank of configuration registers, such as those of a calendar and its prescaler, and keeps stray bus writes out of them. Software opens the bank by writing two fixed key values in turn to a dedicated key register. Any other value written there closes the bank again. While the bank is open, every write to a protected address is passed on with a write-enable qualifier. While it is closed, such writes are dropped without any indication.

A small status register lets software ask for initialisation mode. The block acknowledges the request after a fixed number of calendar-clock ticks. From then until the request is withdrawn, it freezes the counters and allows time, date and prescaler loads. A resynchronisation flag can be cleared by software and is set again by the next one-second update. An "initialised" bit reports whether the year value has left its reset value.

Top module: `cfg_guard`

## Requirements
- R1: After reset the bank is locked (`unlocked_o`=0), `freeze_o`=0, and status bits INIT (bit 0), ACK (bit 1) and SYNC (bit 2) read 0.
- R2: A write of KEY_1 (0xCA, compared on data bits 7:0) to KEY_ADDR, followed by KEY_2 (0x53) as the next write to KEY_ADDR, raises `unlocked_o` on the clock edge of the second write. Writes to other addresses in between do not break the sequence.
- R3: If the write to KEY_ADDR that follows KEY_1 carries any value other than KEY_2, the bank stays locked. KEY_2 written without a preceding KEY_1 does not unlock.
- R4: Any write to KEY_ADDR while the bank is unlocked (for example 0xFF) locks it from the next cycle.
- R5: `prot_we_o` is high in the same cycle as `wr_en_i` exactly when the bank is unlocked and `wr_addr_i` is not KEY_ADDR. While the bank is locked, writes to STAT_ADDR leave the status register unchanged.
- R6: An unlocked write to STAT_ADDR loads INIT from data bit 0, visible from the next cycle. ACK (status bit 1) rises on the edge of the ACK_CYC-th `cal_tick_i` pulse (default 2) after the write cycle.
- R7: `freeze_o` equals ACK. `load_we_o` is high only when `prot_we_o` is high, ACK is set and the address is not STAT_ADDR.
- R8: An unlocked status write with data bit 0 low clears INIT, ACK and `freeze_o` from the next cycle.
- R9: An unlocked status write with data bit 2 low clears SYNC (status bit 2). A `sec_tick_i` pulse while `freeze_o` is low sets SYNC from the next cycle. A pulse while frozen does not set it, and writing bit 2 high never sets it.
- R10: Status bit 3 (INITS) is 1 exactly when `year_i` differs from YEAR_RST (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (6) | Write address |
| wr_data_i | input | DW (32) | Write data |
| cal_tick_i | input | 1 | One pulse per calendar-clock cycle |
| sec_tick_i | input | 1 | One-second calendar update strobe |
| year_i | input | YW (8) | Current year value of the calendar |
| prot_we_o | output | 1 | Write qualifier for protected registers |
| load_we_o | output | 1 | Write qualifier for time, date and prescaler loads |
| freeze_o | output | 1 | Holds the calendar counters |
| unlocked_o | output | 1 | Key sequence has opened the bank |
| status_o | output | 4 | {INITS, SYNC, ACK, INIT} |

## Verification
A wrong key state shows at once on `prot_we_o` during the next write to a protected address, and on `unlocked_o` one edge after the key write. A miscounting acknowledge counter moves the rise of ACK and `freeze_o` by whole calendar ticks, so the bench samples ACK after each tick. A stale SYNC or INIT bit is visible on `status_o` in the cycle after the write or tick that should have changed it. A random mix of key, status and other writes is compared against a bench model every cycle, so a fault surfaces within one cycle of the event that causes it.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  localparam int ST_W     = 4;
  localparam int ST_INIT  = 0;
  localparam int ST_ACK   = 1;
  localparam int ST_SYNC  = 2;
  localparam int ST_INITS = 3;
endpackage

// File: rtl/cfg_guard_key_fsm.sv
module cfg_guard_key_fsm
  import cfg_guard_pkg::*;
#(
  parameter int          KW    = 8,
  parameter logic [KW-1:0] KEY_1 = 8'hCA,
  parameter logic [KW-1:0] KEY_2 = 8'h53
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [KW-1:0] key_i,
  output logic          unlocked_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      if (key_i == KEY_1)                              state_d = LK_HALF;
      else if (state_q == LK_HALF && key_i == KEY_2)   state_d = LK_OPEN;
      else                                             state_d = LK_CLOSED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_CLOSED;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == LK_OPEN);
endmodule

// File: rtl/cfg_guard_init_ctrl.sv
module cfg_guard_init_ctrl #(
  parameter int ACK_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_wr_i,
  input  logic req_val_i,
  input  logic cal_tick_i,
  output logic req_o,
  output logic ack_o
);
  localparam int CW = $clog2(ACK_CYC + 1);

  logic          req_q, req_d, ack_q;
  logic [CW-1:0] cnt_q;

  assign req_d = req_wr_i ? req_val_i : req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      if (!req_d) begin
        ack_q <= 1'b0;
        cnt_q <= '0;
      end else if (req_q && !ack_q && cal_tick_i) begin
        // count ticks strictly after the request was registered
        if (cnt_q == CW'(ACK_CYC - 1)) ack_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_o = req_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/cfg_guard_sync_flag.sv
module cfg_guard_sync_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sec_tick_i,
  input  logic freeze_i,
  output logic sync_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sync_q <= 1'b0;
    else if (clr_i)                     sync_q <= 1'b0;
    else if (sec_tick_i && !freeze_i)   sync_q <= 1'b1;
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            DW        = 32,
  parameter int            KW        = 8,
  parameter int            YW        = 8,
  parameter logic [AW-1:0] KEY_ADDR  = 6'h09,
  parameter logic [AW-1:0] STAT_ADDR = 6'h03,
  parameter logic [KW-1:0] KEY_1     = 8'hCA,
  parameter logic [KW-1:0] KEY_2     = 8'h53,
  parameter int            ACK_CYC   = 2,
  parameter logic [YW-1:0] YEAR_RST  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            cal_tick_i,
  input  logic            sec_tick_i,
  input  logic [YW-1:0]   year_i,
  output logic            prot_we_o,
  output logic            load_we_o,
  output logic            freeze_o,
  output logic            unlocked_o,
  output logic [ST_W-1:0] status_o
);
  logic key_wr, unlocked, stat_wr, req, ack, sync;

  assign key_wr  = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign stat_wr = wr_en_i && (wr_addr_i == STAT_ADDR) && unlocked;

  cfg_guard_key_fsm #(.KW(KW), .KEY_1(KEY_1), .KEY_2(KEY_2)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_i      (wr_data_i[KW-1:0]),
    .unlocked_o (unlocked)
  );

  cfg_guard_init_ctrl #(.ACK_CYC(ACK_CYC)) u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_wr_i   (stat_wr),
    .req_val_i  (wr_data_i[ST_INIT]),
    .cal_tick_i (cal_tick_i),
    .req_o      (req),
    .ack_o      (ack)
  );

  cfg_guard_sync_flag u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (stat_wr && !wr_data_i[ST_SYNC]),
    .sec_tick_i (sec_tick_i),
    .freeze_i   (ack),
    .sync_o     (sync)
  );

  assign prot_we_o  = wr_en_i && unlocked && !key_wr;
  assign load_we_o  = prot_we_o && ack && (wr_addr_i != STAT_ADDR);
  assign freeze_o   = ack;
  assign unlocked_o = unlocked;

  always_comb begin
    status_o           = '0;
    status_o[ST_INIT]  = req;
    status_o[ST_ACK]   = ack;
    status_o[ST_SYNC]  = sync;
    status_o[ST_INITS] = (year_i != YEAR_RST);
  end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int            AW        = 6,
  parameter int            DW        = 32,
  parameter int            KW        = 8,
  parameter logic [AW-1:0] KEY_ADDR  = 6'h09,
  parameter logic [AW-1:0] STAT_ADDR = 6'h03,
  parameter logic [KW-1:0] KEY_2     = 8'h53
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          cal_tick_i,
  input logic          sec_tick_i,
  input logic          prot_we_o,
  input logic          load_we_o,
  input logic          freeze_o,
  input logic          unlocked_o,
  input logic [3:0]    status_o
);
  p_unlock_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i[KW-1:0] == KEY_2));

  p_relock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i[KW-1:0] != KEY_2) |=> !unlocked_o);

  p_locked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |-> (!prot_we_o && !load_we_o));

  p_locked_stat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && !cal_tick_i && !sec_tick_i) |=> $stable(status_o[2:0]));

  p_ack_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> $past(cal_tick_i && status_o[0]));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_o |-> (freeze_o && prot_we_o && wr_addr_i != STAT_ADDR));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_en_i && wr_addr_i == STAT_ADDR && !wr_data_i[0]) |=> (!status_o[1] && !freeze_o));

  p_sync_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(sec_tick_i && !freeze_o));
endmodule

bind cfg_guard cfg_guard_chk #(
  .AW(AW), .DW(DW), .KW(KW), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR), .KEY_2(KEY_2)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .cal_tick_i(cal_tick_i), .sec_tick_i(sec_tick_i),
  .prot_we_o(prot_we_o), .load_we_o(load_we_o), .freeze_o(freeze_o),
  .unlocked_o(unlocked_o), .status_o(status_o)
);

// File: tb/cfg_guard_bench.sv
module cfg_guard_bench;
  localparam logic [5:0] KA = 6'h09;
  localparam logic [5:0] SA = 6'h03;
  localparam logic [5:0] OA = 6'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] data = '0;
  logic        ct = 1'b0, st = 1'b0;
  logic [7:0]  year = '0;
  logic        prot_we, load_we, freeze, unlocked;
  logic [3:0]  status;

  int n_chk = 0, n_err = 0;
  int m_lock = 0, m_cnt = 0;
  bit m_req = 0, m_ack = 0, m_sync = 0;

  always #10 clk = ~clk;

  cfg_guard u_cfg_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .cal_tick_i(ct), .sec_tick_i(st), .year_i(year),
    .prot_we_o(prot_we), .load_we_o(load_we), .freeze_o(freeze),
    .unlocked_o(unlocked), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_status();
    return {28'd0, year != 8'd0, m_sync, m_ack, m_req};
  endfunction

  // one cycle: drive, check combinational qualifiers, advance model, check state
  task automatic step(input bit w, input logic [5:0] a, input logic [31:0] d,
                      input bit c, input bit s);
    bit unl, e_prot, e_load, sw, req_n;
    @(negedge clk);
    we = w; addr = a; data = d; ct = c; st = s;
    #3;
    unl    = (m_lock == 2);
    e_prot = w && unl && (a != KA);
    e_load = e_prot && m_ack && (a != SA);
    chk(prot_we == e_prot, "R5 prot_we", prot_we, e_prot);
    chk(load_we == e_load, "R7 load_we", load_we, e_load);
    @(posedge clk);
    if (w && a == KA)
      m_lock = (d[7:0] == 8'hCA) ? 1 : (m_lock == 1 && d[7:0] == 8'h53) ? 2 : 0;
    sw    = w && a == SA && unl;
    req_n = sw ? d[0] : m_req;
    if (sw && !d[2]) m_sync = 0;
    else if (s && !m_ack) m_sync = 1;
    if (!req_n) begin m_ack = 0; m_cnt = 0; end
    else if (m_req && !m_ack && c) begin
      if (m_cnt == 1) m_ack = 1;
      m_cnt++;
    end
    m_req = req_n;
    #1;
    chk(unlocked == (m_lock == 2), "R2 unlocked", unlocked, m_lock == 2);
    chk(int'(status) == exp_status(), "R6 R9 R10 status", status, exp_status());
    chk(freeze == m_ack, "R7 freeze", freeze, m_ack);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    #45 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!unlocked, "R1 unlocked", unlocked, 0);
    chk(status[2:0] == 3'b000, "R1 status", status, 0);
    chk(!freeze, "R1 freeze", freeze, 0);

    // R3 KEY_2 alone, and wrong second key
    step(1, KA, 32'h53, 0, 0);
    chk(!unlocked, "R3 key2 alone", unlocked, 0);
    step(1, KA, 32'hCA, 0, 0);
    step(1, KA, 32'h54, 0, 0);
    chk(!unlocked, "R3 wrong second key", unlocked, 0);

    // R5 locked status write ignored
    step(1, SA, 32'h1, 1, 0);
    chk(status[0] == 0, "R5 locked INIT write", status[0], 0);

    // R2 unlock with other-address write in between
    step(1, KA, 32'hCA, 0, 0);
    step(1, OA, 32'h0, 0, 0);
    step(1, KA, 32'hFFFF_FF53, 0, 0);
    chk(unlocked, "R2 unlock", unlocked, 1);

    // R9 SYNC set by second tick, cleared by write
    step(0, OA, 0, 0, 1);
    chk(status[2], "R9 sync set", status[2], 1);
    step(1, SA, 32'h0, 0, 0);
    chk(!status[2], "R9 sync clear", status[2], 0);
    step(1, SA, 32'h4, 0, 0);
    chk(!status[2], "R9 write one no set", status[2], 0);

    // R6 init request and ACK timing
    step(1, SA, 32'h1, 1, 0);
    chk(status[0] && !status[1], "R6 req no ack", status, 1);
    step(0, OA, 0, 1, 0);
    chk(!status[1], "R6 after first tick", status[1], 0);
    step(0, OA, 0, 0, 0);
    step(0, OA, 0, 1, 0);
    chk(status[1] && freeze, "R6 ack after second tick", status[1], 1);
    step(1, OA, 32'h5, 0, 0);   // load while frozen: R7
    step(0, OA, 0, 0, 1);
    chk(!status[2], "R9 no set while frozen", status[2], 0);

    // R8 leave init mode
    step(1, SA, 32'h0, 0, 0);
    chk(!status[0] && !status[1] && !freeze, "R8 exit", status, 0);

    // R4 relock with 0xFF
    step(1, KA, 32'hFF, 0, 0);
    chk(!unlocked, "R4 relock", unlocked, 0);

    // R10 INITS
    year = 8'h17;
    #1;
    chk(status[3], "R10 inits set", status[3], 1);
    year = 8'h00;
    #1;
    chk(!status[3], "R10 inits clear", status[3], 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [5:0]  a;
      logic [31:0] d;
      if (sel < 4) begin
        a = KA;
        case ($urandom_range(0, 3))
          0, 1: d = 32'hCA;
          2:    d = 32'h53;
          default: d = $urandom;
        endcase
        if (sel == 0) d = ($urandom_range(0, 1) != 0) ? 32'h53 : 32'hCA;
      end else if (sel < 7) begin
        a = SA; d = {28'd0, 4'($urandom)};
      end else begin
        a = 6'($urandom); d = $urandom;
      end
      if ($urandom_range(0, 49) == 0) year = 8'($urandom_range(0, 3));
      step($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0);
    end
    finish_up();
  end
endmodule